// File: doc/BRIEF.md
# Bit-manipulation execution unit

This unit computes the result of one basic bit-manipulation operation per cycle for an integer pipeline. It counts leading zeros, trailing zeros and set bits, performs logic with an inverted second operand, selects the signed or unsigned minimum or maximum, sign-extends a byte or halfword, rotates, reverses byte order and collapses each byte to all-ones or all-zeros. The datapath width XLEN is a parameter of 32 or 64.

On a 64-bit build, a word flag applies the counts and rotates to the low 32 bits only: zero counts then saturate at 32, and word rotates sign-extend their 32-bit result. An operation code that is not defined, or a word-flagged operation that has no word form (or any word-flagged operation on a 32-bit build), raises the illegal flag. The result appears in a register one clock after a valid request, with a matching valid strobe.

Top module: `bitmanip_alu`

## Requirements
- R1: When valid_i is high at a rising clock edge, valid_o, result_o and illegal_o show that request's outcome after that edge; when valid_i is low, valid_o drops and result_o and illegal_o keep their values. An asynchronous low rst_ni clears all three outputs.
- R2: op_i codes are 0 CLZ, 1 CTZ, 2 CPOP, 3 ANDN, 4 ORN, 5 XNOR, 6 MIN, 7 MAX, 8 MINU, 9 MAXU, 10 SEXTB, 11 SEXTH, 12 ROR, 13 ROL, 14 RORI, 15 REV8, 16 ORCB; codes 17 to 31 set illegal_o, and any illegal request yields result_o of zero.
- R3: CLZ and CTZ return the count of zero bits above the highest or below the lowest set bit of a_i, and return XLEN when a_i is zero.
- R4: CPOP returns the number of ones in a_i.
- R5: ANDN, ORN and XNOR return a_i AND, OR or XOR the complement of b_i.
- R6: MIN and MAX pick between a_i and b_i as two's-complement numbers; MINU and MAXU pick as unsigned numbers.
- R7: SEXTB copies a_i bit 7 into every higher bit of the result; SEXTH copies bit 15.
- R8: ROR and ROL rotate a_i right or left by the low log2(XLEN) bits of b_i; RORI rotates right by the low log2(XLEN) bits of imm_i.
- R9: REV8 returns a_i with its bytes in reverse order.
- R10: ORCB sets each result byte to 0xFF when the byte of a_i in the same position is nonzero and to 0x00 otherwise.
- R11: With word_i high on a 64-bit build, CLZ, CTZ and CPOP consider only a_i[31:0], CLZ and CTZ returning 32 when those bits are zero.
- R12: With word_i high on a 64-bit build, ROR, ROL and RORI rotate a_i[31:0] by the low 5 bits of the amount and sign-extend bit 31 of the 32-bit result to 64 bits.
- R13: word_i high together with an operation other than CLZ, CTZ, CPOP, ROR, ROL or RORI, or with any operation on a 32-bit build, sets illegal_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 5 | Operation code |
| word_i | input | 1 | Apply to low 32 bits (word form) |
| a_i | input | XLEN | First operand |
| b_i | input | XLEN | Second operand / rotate amount |
| imm_i | input | 6 | Immediate rotate amount |
| valid_o | output | 1 | Result strobe |
| result_o | output | XLEN | Registered result |
| illegal_o | output | 1 | Request not supported |

## Verification
The only state is the output register, so a fault shows at the ports on the first edge after the request that excites it: a wrong operand path or sign extension appears as a wrong result_o in that very cycle, and a broken hold appears as a changed result_o on the first idle cycle. Corner operands are aimed at the saturation of zero counts, the signed versus unsigned ordering of extreme values, rotate amounts at zero, the top value and just past the field width, and word forms with garbage in the upper half, which would leak into a result whose word masking or sign extension is broken.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [4:0] {
    OP_CLZ   = 5'd0,
    OP_CTZ   = 5'd1,
    OP_CPOP  = 5'd2,
    OP_ANDN  = 5'd3,
    OP_ORN   = 5'd4,
    OP_XNOR  = 5'd5,
    OP_MIN   = 5'd6,
    OP_MAX   = 5'd7,
    OP_MINU  = 5'd8,
    OP_MAXU  = 5'd9,
    OP_SEXTB = 5'd10,
    OP_SEXTH = 5'd11,
    OP_ROR   = 5'd12,
    OP_ROL   = 5'd13,
    OP_RORI  = 5'd14,
    OP_REV8  = 5'd15,
    OP_ORCB  = 5'd16
  } bm_op_e;

  localparam int unsigned OP_LAST = 16;
endpackage

// File: rtl/bm_count.sv
module bm_count #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned CW = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0] val_i,
  input  logic            word_i,
  output logic [CW-1:0]   lead_o,
  output logic [CW-1:0]   trail_o,
  output logic [CW-1:0]   ones_o
);
  int unsigned lim;
  logic seen_hi, seen_lo;

  always_comb begin
    lim     = word_i ? 32 : XLEN;
    lead_o  = '0;
    trail_o = '0;
    ones_o  = '0;
    seen_hi = 1'b0;
    seen_lo = 1'b0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (i < lim && !seen_hi) begin
        if (val_i[i]) seen_hi = 1'b1;
        else          lead_o  = lead_o + 1'b1;
      end
    end
    for (int i = 0; i < XLEN; i++) begin
      if (i < lim) begin
        if (!seen_lo) begin
          if (val_i[i]) seen_lo = 1'b1;
          else          trail_o = trail_o + 1'b1;
        end
        ones_o = ones_o + CW'(val_i[i]);
      end
    end
  end
endmodule

// File: rtl/bm_rotate.sv
module bm_rotate #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned SW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [SW-1:0]   amt_i,
  input  logic            left_i,
  input  logic            word_i,
  output logic [XLEN-1:0] res_o
);
  logic [SW-1:0]     rsh;
  logic [4:0]        wsh;
  logic [2*XLEN-1:0] full_dbl;
  logic [63:0]       word_dbl;
  logic [31:0]       word_res;

  // left rotate == right rotate by the negated amount (mod width)
  assign rsh      = left_i ? (~amt_i + 1'b1) : amt_i;
  assign wsh      = left_i ? (~amt_i[4:0] + 1'b1) : amt_i[4:0];
  assign full_dbl = {val_i, val_i} >> rsh;
  assign word_dbl = {val_i[31:0], val_i[31:0]} >> wsh;
  assign word_res = word_dbl[31:0];

  generate
    if (XLEN > 32) begin : g_wide
      assign res_o = word_i ? {{(XLEN-32){word_res[31]}}, word_res} : full_dbl[XLEN-1:0];
    end else begin : g_narrow
      assign res_o = full_dbl[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/bm_bytes.sv
module bm_bytes #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned NB = XLEN / 8
) (
  input  logic [XLEN-1:0] val_i,
  output logic [XLEN-1:0] rev_o,
  output logic [XLEN-1:0] orc_o
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign rev_o[8*g +: 8] = val_i[8*(NB-1-g) +: 8];
    assign orc_o[8*g +: 8] = {8{|val_i[8*g +: 8]}};
  end
endmodule

// File: rtl/bitmanip_alu.sv
module bitmanip_alu #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [4:0]      op_i,
  input  logic            word_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [5:0]      imm_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  import bm_pkg::*;

  localparam int unsigned SW = $clog2(XLEN);
  localparam int unsigned CW = SW + 1;

  bm_op_e          op;
  logic            word_ok, ill;
  logic [CW-1:0]   lead, trail, ones;
  logic [SW-1:0]   amt;
  logic [XLEN-1:0] rot, rev, orc, sel, nxt;

  assign op = bm_op_e'(op_i);

  bm_count #(.XLEN(XLEN)) u_count (
    .val_i (a_i), .word_i (word_i),
    .lead_o (lead), .trail_o (trail), .ones_o (ones)
  );

  assign amt = (op == OP_RORI) ? imm_i[SW-1:0] : b_i[SW-1:0];

  bm_rotate #(.XLEN(XLEN)) u_rot (
    .val_i (a_i), .amt_i (amt), .left_i (op == OP_ROL),
    .word_i (word_i), .res_o (rot)
  );

  bm_bytes #(.XLEN(XLEN)) u_bytes (.val_i (a_i), .rev_o (rev), .orc_o (orc));

  always_comb begin
    unique case (op)
      OP_CLZ, OP_CTZ, OP_CPOP, OP_ROR, OP_ROL, OP_RORI: word_ok = (XLEN > 32);
      default:                                          word_ok = 1'b0;
    endcase
  end

  assign ill = (int'(op_i) > OP_LAST) || (word_i && !word_ok);

  always_comb begin
    case (op)
      OP_CLZ:   sel = {{(XLEN-CW){1'b0}}, lead};
      OP_CTZ:   sel = {{(XLEN-CW){1'b0}}, trail};
      OP_CPOP:  sel = {{(XLEN-CW){1'b0}}, ones};
      OP_ANDN:  sel = a_i & ~b_i;
      OP_ORN:   sel = a_i | ~b_i;
      OP_XNOR:  sel = a_i ^ ~b_i;
      OP_MIN:   sel = ($signed(a_i) < $signed(b_i)) ? a_i : b_i;
      OP_MAX:   sel = ($signed(a_i) < $signed(b_i)) ? b_i : a_i;
      OP_MINU:  sel = (a_i < b_i) ? a_i : b_i;
      OP_MAXU:  sel = (a_i < b_i) ? b_i : a_i;
      OP_SEXTB: sel = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
      OP_SEXTH: sel = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
      OP_ROR, OP_ROL, OP_RORI: sel = rot;
      OP_REV8:  sel = rev;
      OP_ORCB:  sel = orc;
      default:  sel = '0;
    endcase
  end

  assign nxt = ill ? '0 : sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= nxt;
        illegal_o <= ill;
      end
    end
  end
endmodule

// File: rtl/bitmanip_alu_chk.sv
module bitmanip_alu_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [4:0]      op_i,
  input logic            word_i,
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic [5:0]      imm_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o
);
  import bm_pkg::*;

  logic is_wop, is_rot;
  assign is_rot = (op_i == OP_ROR) || (op_i == OP_ROL) || (op_i == OP_RORI);
  assign is_wop = is_rot || (op_i == OP_CLZ) || (op_i == OP_CTZ) || (op_i == OP_CPOP);

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_VALID_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(illegal_o)); // R1
  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && illegal_o |-> result_o == '0); // R2
  AST_CPOP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !word_i && op_i == OP_CPOP |=> result_o <= XLEN); // R4
  AST_SEXTB_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !word_i && op_i == OP_SEXTB |=>
      (&result_o[XLEN-1:7]) || !(|result_o[XLEN-1:7])); // R7
  AST_WORD_COUNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && word_i && XLEN > 32 && (op_i == OP_CLZ || op_i == OP_CTZ) |=>
      result_o <= 32); // R11
  AST_WORD_ROT_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && word_i && XLEN > 32 && is_rot |=>
      (&result_o[XLEN-1:31]) || !(|result_o[XLEN-1:31])); // R12
  AST_WORD_BAD_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && word_i && !is_wop |=> illegal_o); // R13
endmodule

bind bitmanip_alu bitmanip_alu_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bitmanip_alu_test.sv
module bitmanip_alu_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [4:0]      op_i = '0;
  logic            word_i = 1'b0;
  logic [XLEN-1:0] a_i = '0, b_i = '0;
  logic [5:0]      imm_i = '0;
  logic            valid_o, illegal_o;
  logic [XLEN-1:0] result_o;

  int checks = 0, errors = 0;
  logic            exp_valid = 1'b0, exp_ill = 1'b0;
  logic [XLEN-1:0] exp_res = '0;
  string           cur_req = "R1";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bitmanip_alu #(.XLEN(XLEN)) uut (.*);

  function automatic string req_of(int op, logic w);
    if (op > 16) return "R2";
    if (w) begin
      if (op <= 2) return "R11";
      if (op >= 12 && op <= 14) return "R12";
      return "R13";
    end
    case (op)
      0, 1: return "R3";
      2: return "R4";
      3, 4, 5: return "R5";
      6, 7, 8, 9: return "R6";
      10, 11: return "R7";
      12, 13, 14: return "R8";
      15: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic void ref_model(input int op, input logic w,
      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [5:0] imm,
      output logic ill, output logic [XLEN-1:0] r);
    int lim, n, s;
    lim = w ? 32 : XLEN;
    r = '0;
    ill = (op > 16) || (w && !(op <= 2 || (op >= 12 && op <= 14)));
    if (ill) return;
    case (op)
      0: begin n = 0; while (n < lim && !a[lim-1-n]) n++; r = XLEN'(n); end
      1: begin n = 0; while (n < lim && !a[n]) n++; r = XLEN'(n); end
      2: begin n = 0; for (int i = 0; i < lim; i++) n += a[i]; r = XLEN'(n); end
      3: r = a & ~b;
      4: r = a | ~b;
      5: r = ~(a ^ b);
      6: r = ($signed(a) <= $signed(b)) ? a : b;
      7: r = ($signed(a) >= $signed(b)) ? a : b;
      8: r = (a <= b) ? a : b;
      9: r = (a >= b) ? a : b;
      10: for (int i = 0; i < XLEN; i++) r[i] = (i < 8) ? a[i] : a[7];
      11: for (int i = 0; i < XLEN; i++) r[i] = (i < 16) ? a[i] : a[15];
      12, 13, 14: begin
        s = (op == 14) ? int'(imm) : int'(b[5:0]);
        s = s % lim;
        if (op == 13) s = (lim - s) % lim;
        for (int i = 0; i < lim; i++) r[i] = a[(i + s) % lim];
        if (w) for (int i = 32; i < XLEN; i++) r[i] = r[31];
      end
      15: for (int k = 0; k < XLEN/8; k++) r[8*k +: 8] = a[XLEN-8-8*k +: 8];
      default: for (int k = 0; k < XLEN/8; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (valid_o !== exp_valid || illegal_o !== exp_ill || result_o !== exp_res) begin
      errors++;
      $display("FAIL %s: actual v=%0b ill=%0b res=%h expected v=%0b ill=%0b res=%h",
               cur_req, valid_o, illegal_o, result_o, exp_valid, exp_ill, exp_res);
    end
  endtask

  task automatic step(input logic v, input int op, input logic w,
      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [5:0] imm);
    logic ill;
    logic [XLEN-1:0] r;
    @(negedge clk_i);
    compare();
    valid_i = v; op_i = 5'(op); word_i = w; a_i = a; b_i = b; imm_i = imm;
    exp_valid = v;
    if (v) begin
      ref_model(op, w, a, b, imm, ill, r);
      exp_ill = ill; exp_res = r; cur_req = req_of(op, w);
    end else begin
      cur_req = "R1";
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // reset state
    repeat (2) begin @(negedge clk_i); compare(); end
    rst_ni = 1'b1;
    // R3 zero operand saturation, R11 word counts with upper garbage
    step(1, 0, 0, '0, '0, 0);
    step(1, 1, 0, '0, '0, 0);
    step(1, 0, 0, 64'h0000_0100_0000_0000, '0, 0);
    step(1, 1, 0, 64'h8000_0000_0000_0000, '0, 0);
    step(1, 0, 1, 64'hFFFF_FFFF_0000_0000, '0, 0);
    step(1, 1, 1, 64'hFFFF_FFFF_0000_0000, '0, 0);
    step(1, 0, 1, 64'h1234_5678_0000_8000, '0, 0);
    step(1, 1, 1, 64'h0000_0000_0004_0000, '0, 0);
    // R4 population counts
    step(1, 2, 0, '1, '0, 0);
    step(1, 2, 1, 64'hFFFF_FFFF_F0F0_0001, '0, 0);
    // R5 inverted-operand logic
    step(1, 3, 0, 64'hFF00_FF00_1234_5678, 64'h0F0F_0F0F_0000_FFFF, 0);
    step(1, 4, 0, 64'hFF00_FF00_1234_5678, 64'h0F0F_0F0F_0000_FFFF, 0);
    step(1, 5, 0, 64'hFF00_FF00_1234_5678, 64'h0F0F_0F0F_0000_FFFF, 0);
    // R6 signed versus unsigned ordering
    for (int op = 6; op <= 9; op++) begin
      step(1, op, 0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 0);
      step(1, op, 0, '1, 64'd1, 0);
      step(1, op, 0, 64'd5, 64'd5, 0);
    end
    // R7 sign extension both polarities
    step(1, 10, 0, 64'h1234_5678_9ABC_DE80, '0, 0);
    step(1, 10, 0, 64'hFFFF_FFFF_FFFF_FF7F, '0, 0);
    step(1, 11, 0, 64'h0000_0000_0000_8001, '0, 0);
    step(1, 11, 0, 64'hFFFF_FFFF_FFFF_7FFF, '0, 0);
    // R8 rotates at amount 0, max, wrap of b
    step(1, 12, 0, 64'h0123_4567_89AB_CDEF, 64'd0, 0);
    step(1, 12, 0, 64'h0123_4567_89AB_CDEF, 64'd63, 0);
    step(1, 12, 0, 64'h0123_4567_89AB_CDEF, 64'd68, 0);
    step(1, 13, 0, 64'h8000_0000_0000_0001, 64'd1, 0);
    step(1, 14, 0, 64'h0123_4567_89AB_CDEF, '1, 6'd8);
    // R12 word rotates
    step(1, 12, 1, 64'hDEAD_BEEF_0000_0001, 64'd1, 0);
    step(1, 13, 1, 64'h0000_0000_4000_0000, 64'd33, 0);
    step(1, 14, 1, 64'hFFFF_FFFF_0000_00F0, '0, 6'd36);
    step(1, 12, 1, 64'h0000_0000_8000_0000, 64'd0, 0);
    // R9 byte reverse, R10 or-combine
    step(1, 15, 0, 64'h0102_0304_0506_0708, '0, 0);
    step(1, 16, 0, 64'h0001_0000_8000_00FF, '0, 0);
    step(1, 16, 0, '0, '0, 0);
    // R2 undefined codes, R13 word misuse
    step(1, 17, 0, '1, '1, 6'h3F);
    step(1, 31, 0, '1, '1, 6'h3F);
    step(1, 3, 1, '1, '0, 0);
    step(1, 15, 1, '1, '0, 0);
    // R1 idle cycles hold the last result
    step(1, 15, 0, 64'h1122_3344_5566_7788, '0, 0);
    step(0, 2, 0, '1, '1, 0);
    step(0, 17, 1, '0, '0, 0);
    // mixed patterns
    for (int k = 0; k < 400; k++) begin
      step(($urandom_range(0, 4) != 0), $urandom_range(0, 18), ($urandom_range(0, 3) == 0),
           {$urandom, $urandom}, {$urandom, $urandom}, 6'($urandom));
    end
    step(0, 0, 0, '0, '0, 0);
    @(negedge clk_i);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule